// File: doc/BRIEF.md
# Staged Reset Sequencer

This block merges four reset requests into a single reset event and hands reset release to three downstream domains one after another. Two requests are asynchronous: a power-on request and an active-low board pin. Two are synchronous: a software request set through a control bit, and a watchdog expiry pulse. Any request pulls every domain reset low at once. Release always happens on a rising clock edge, first to the clock generator, then to the peripherals and last to the processor core.

A power-on event first runs a long settling stretch of 2^STAB_LOG2 cycles. After that come three windows of WIN_LEN cycles each. The other sources skip the stretch and enter the windows directly. A request that arrives while a sequence is running starts the sequence again from the beginning.

A small register interface sets the software request bit and clears the sticky cause flags. The flags record which sources have caused a reset since they were last cleared.

Top module: `rstseq_top`

## Requirements
- R1: Raising `por_req` or pulling `ext_rst_n` low drives `clkgen_rst_n`, `periph_rst_n` and `core_rst_n` low at once, with no clock edge needed, and they stay low while that source is held.
- R2: After an asynchronous source is removed, its internal hold lasts until the second rising clock edge. The sequence is entered on that edge.
- R3: A power-on sequence spends 2^STAB_LOG2 cycles in a settling stretch before the first window. The pin, software and watchdog sequences have no stretch.
- R4: Counted from the edge on which the windows begin, `clkgen_rst_n` rises WIN_LEN edges later, `periph_rst_n` rises 2·WIN_LEN edges later and `core_rst_n` rises 3·WIN_LEN edges later.
- R5: `periph_rst_n` is never high while `clkgen_rst_n` is low, and `core_rst_n` is never high while `periph_rst_n` is low.
- R6: A new request that arrives during a sequence drops all three outputs and restarts the windows from the first one.
- R7: A write with `reg_sel`=0 and `reg_wdata[0]`=1 sets `sw_rst_bit` on that edge. On the next edge the sequence is entered and the bit clears itself, so it reads 1 for exactly one cycle.
- R8: If `wdog_expire` is high at a rising edge, the sequence is entered on that edge.
- R9: The bits of `cause_flags` are sticky and are set when their source triggers: bit 0 power-on, bit 1 pin, bit 2 software, bit 3 watchdog.
- R10: A power-on event sets `cause_flags` to 4'b0001. A write with `reg_sel`=1 clears each flag whose `reg_wdata` bit is 1 and leaves the others unchanged. When a flag is set and cleared on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Asynchronous power-on request, active high |
| ext_rst_n | input | 1 | Asynchronous board reset pin, active low |
| wdog_expire | input | 1 | Synchronous watchdog expiry pulse |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control bit, 1 selects the cause flags |
| reg_wdata | input | 4 | Write data |
| clkgen_rst_n | output | 1 | Clock-generator reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| core_rst_n | output | 1 | Core reset, active low |
| sw_rst_bit | output | 1 | Readback of the software request bit |
| cause_flags | output | 4 | Sticky reset cause flags |

## Verification
The checker assumes that `wdog_expire` and the register strobe are single-cycle pulses driven away from the clock edge. It also assumes that the power-on request is high from the start of time, so every clocked property can be masked by `por_req`. The bench drives every input on the falling edge and holds asynchronous sources for several cycles. It lets each sequence run to full core release before the next request, except in the restart test, which fires a second watchdog pulse on purpose once the clock generator has been released.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int NUM_SRC  = 4;
    localparam int SRC_POR  = 0;
    localparam int SRC_PIN  = 1;
    localparam int SRC_SW   = 2;
    localparam int SRC_WDOG = 3;

    typedef enum logic [2:0] {
        ST_STAB,
        ST_CLKEN,
        ST_PERIPH,
        ST_CORE,
        ST_RUN
    } seq_stage_e;

    typedef struct packed {
        logic clkgen;
        logic periph;
        logic core;
    } rel_t;

    function automatic rel_t rel_of(seq_stage_e s);
        rel_t r;
        r = '0;
        case (s)
            ST_PERIPH: r = '{clkgen: 1'b1, periph: 1'b0, core: 1'b0};
            ST_CORE:   r = '{clkgen: 1'b1, periph: 1'b1, core: 1'b0};
            ST_RUN:    r = '{clkgen: 1'b1, periph: 1'b1, core: 1'b1};
            default:   r = '0;
        endcase
        return r;
    endfunction

    function automatic seq_stage_e next_window(seq_stage_e s);
        seq_stage_e n;
        case (s)
            ST_STAB:   n = ST_CLKEN;
            ST_CLKEN:  n = ST_PERIPH;
            ST_PERIPH: n = ST_CORE;
            default:   n = ST_RUN;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_in,
    output logic hold
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or posedge arst_in) begin
        if (arst_in) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign hold = ~chain_q[STAGES-1];
endmodule

// File: rtl/rstseq_stager.sv
module rstseq_stager
    import rstseq_pkg::*;
#(
    parameter int STAB_LOG2 = 21,
    parameter int WIN_LEN   = 32
) (
    input  logic clk,
    input  logic por_hold,
    input  logic restart,
    output rel_t rel_o
);
    localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam int CW    = ((STAB_LOG2 > WIN_W) ? STAB_LOG2 : WIN_W) + 1;
    localparam logic [CW-1:0] STAB_LAST = CW'((64'd1 << STAB_LOG2) - 64'd1);
    localparam logic [CW-1:0] WIN_LAST  = CW'(WIN_LEN - 1);

    seq_stage_e    stage_q, stage_d;
    logic [CW-1:0] cnt_q, cnt_d;
    rel_t          rel_q;

    always_comb begin
        stage_d = stage_q;
        cnt_d   = cnt_q;
        if (por_hold) begin
            stage_d = ST_STAB;
            cnt_d   = '0;
        end else if (restart) begin
            stage_d = ST_CLKEN;
            cnt_d   = '0;
        end else begin
            case (stage_q)
                ST_STAB: begin
                    if (cnt_q == STAB_LAST) begin
                        stage_d = next_window(stage_q);
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_CLKEN, ST_PERIPH, ST_CORE: begin
                    if (cnt_q == WIN_LAST) begin
                        stage_d = next_window(stage_q);
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    stage_d = ST_RUN;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        stage_q <= stage_d;
        cnt_q   <= cnt_d;
        rel_q   <= rel_of(stage_d);
    end

    assign rel_o = rel_q;
endmodule

// File: rtl/rstseq_regs.sv
module rstseq_regs
    import rstseq_pkg::*;
(
    input  logic               clk,
    input  logic               por_hold,
    input  logic               pin_hold,
    input  logic               wdog_expire,
    input  logic               reg_we,
    input  logic               reg_sel,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic               sw_q,
    output logic [NUM_SRC-1:0] cause_q
);
    logic               sw_set;
    logic [NUM_SRC-1:0] flag_set, flag_clr;

    assign sw_set = reg_we & ~reg_sel & reg_wdata[0];

    always_comb begin
        flag_set           = '0;
        flag_set[SRC_PIN]  = pin_hold;
        flag_set[SRC_SW]   = sw_q;
        flag_set[SRC_WDOG] = wdog_expire;
        flag_clr           = (reg_we & reg_sel) ? reg_wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (por_hold || pin_hold) begin
            sw_q <= 1'b0;
        end else if (sw_q) begin
            sw_q <= 1'b0;
        end else begin
            sw_q <= sw_set;
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (por_hold) begin
                cause_q[i] <= (i == SRC_POR);
            end else if (flag_set[i]) begin
                cause_q[i] <= 1'b1;
            end else if (flag_clr[i]) begin
                cause_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int STAB_LOG2   = 21,
    parameter int WIN_LEN     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               por_req,
    input  logic               ext_rst_n,
    input  logic               wdog_expire,
    input  logic               reg_we,
    input  logic               reg_sel,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic               clkgen_rst_n,
    output logic               periph_rst_n,
    output logic               core_rst_n,
    output logic               sw_rst_bit,
    output logic [NUM_SRC-1:0] cause_flags
);
    localparam int NUM_ASYNC = 2;

    logic [NUM_ASYNC-1:0] async_req;
    logic [NUM_ASYNC-1:0] async_hold;
    logic                 por_hold, pin_hold, any_hold;
    logic                 sw_q;
    rel_t                 rel;

    assign async_req[0] = por_req;
    assign async_req[1] = ~ext_rst_n;

    for (genvar g = 0; g < NUM_ASYNC; g++) begin : g_sync
        rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .arst_in (async_req[g]),
            .hold    (async_hold[g])
        );
    end

    assign por_hold = async_hold[0];
    assign pin_hold = async_hold[1];
    assign any_hold = por_hold | pin_hold;

    rstseq_regs u_regs (
        .clk         (clk),
        .por_hold    (por_hold),
        .pin_hold    (pin_hold),
        .wdog_expire (wdog_expire),
        .reg_we      (reg_we),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .sw_q        (sw_q),
        .cause_q     (cause_flags)
    );

    rstseq_stager #(.STAB_LOG2(STAB_LOG2), .WIN_LEN(WIN_LEN)) u_stager (
        .clk      (clk),
        .por_hold (por_hold),
        .restart  (pin_hold | sw_q | wdog_expire),
        .rel_o    (rel)
    );

    assign clkgen_rst_n = rel.clkgen & ~any_hold;
    assign periph_rst_n = rel.periph & ~any_hold;
    assign core_rst_n   = rel.core   & ~any_hold;
    assign sw_rst_bit   = sw_q;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
    parameter int WIN_LEN = 32
) (
    input logic       clk,
    input logic       por_req,
    input logic       ext_rst_n,
    input logic       wdog_expire,
    input logic       clkgen_rst_n,
    input logic       periph_rst_n,
    input logic       core_rst_n,
    input logic       sw_rst_bit,
    input logic [3:0] cause_flags
);
    localparam int GW = $clog2(WIN_LEN + 1) + 1;
    localparam logic [GW-1:0] GMAX = '1;

    logic [GW-1:0] gap_clk, gap_per;

    always_ff @(posedge clk) begin
        if (!clkgen_rst_n) gap_clk <= '0;
        else if (gap_clk != GMAX) gap_clk <= gap_clk + 1'b1;
        if (!periph_rst_n) gap_per <= '0;
        else if (gap_per != GMAX) gap_per <= gap_per + 1'b1;
    end

    a_r1_pin_forces_low: assert property (@(posedge clk) disable iff (por_req)
        !ext_rst_n |-> (!clkgen_rst_n && !periph_rst_n && !core_rst_n));

    a_r5_periph_after_clkgen: assert property (@(posedge clk) disable iff (por_req)
        periph_rst_n |-> clkgen_rst_n);

    a_r5_core_after_periph: assert property (@(posedge clk) disable iff (por_req)
        core_rst_n |-> periph_rst_n);

    a_r4_periph_window: assert property (@(posedge clk) disable iff (por_req)
        $rose(periph_rst_n) |-> (gap_clk == GW'(WIN_LEN)));

    a_r4_core_window: assert property (@(posedge clk) disable iff (por_req)
        $rose(core_rst_n) |-> (gap_per == GW'(WIN_LEN)));

    a_r7_sw_one_cycle: assert property (@(posedge clk) disable iff (por_req)
        sw_rst_bit |=> !sw_rst_bit);

    a_r8_wdog_drops_all: assert property (@(posedge clk) disable iff (por_req)
        wdog_expire |=> (!clkgen_rst_n && !periph_rst_n && !core_rst_n));

    a_r9_wdog_flag: assert property (@(posedge clk) disable iff (por_req)
        wdog_expire |=> cause_flags[3]);
endmodule

bind rstseq_top rstseq_chk #(.WIN_LEN(WIN_LEN)) u_chk (
    .clk          (clk),
    .por_req      (por_req),
    .ext_rst_n    (ext_rst_n),
    .wdog_expire  (wdog_expire),
    .clkgen_rst_n (clkgen_rst_n),
    .periph_rst_n (periph_rst_n),
    .core_rst_n   (core_rst_n),
    .sw_rst_bit   (sw_rst_bit),
    .cause_flags  (cause_flags)
);

// File: tb/sim_rstseq_top.sv
module sim_rstseq_top;
    localparam int CLK_PERIOD = 10;
    localparam int TB_STAB    = 6;
    localparam int TB_WIN     = 32;
    localparam int STAB_CYC   = 1 << TB_STAB;
    localparam int K_WDOG = 0, K_SW = 1, K_PIN = 2, K_POR = 3;
    // {kind[1:0], expected cause flags}
    localparam logic [5:0] VEC [0:5] = '{
        {2'd0, 4'b1000}, {2'd1, 4'b0100}, {2'd2, 4'b0010},
        {2'd3, 4'b0001}, {2'd1, 4'b0100}, {2'd0, 4'b1000}
    };

    logic       clk = 1'b0;
    logic       por_req = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       wdog_expire = 1'b0;
    logic       reg_we = 1'b0;
    logic       reg_sel = 1'b0;
    logic [3:0] reg_wdata = '0;
    logic       clkgen_rst_n, periph_rst_n, core_rst_n, sw_rst_bit;
    logic [3:0] cause_flags;

    int n_chk = 0;
    int n_bad = 0;

    rstseq_top #(.STAB_LOG2(TB_STAB), .WIN_LEN(TB_WIN)) u0 (
        .clk, .por_req, .ext_rst_n, .wdog_expire, .reg_we, .reg_sel, .reg_wdata,
        .clkgen_rst_n, .periph_rst_n, .core_rst_n, .sw_rst_bit, .cause_flags
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_all_low(input string req);
        chk({clkgen_rst_n, periph_rst_n, core_rst_n} == 3'b000, req,
            {clkgen_rst_n, periph_rst_n, core_rst_n}, 0);
    endtask

    // lat: posedges from the current negedge to the edge that begins the windows
    task automatic measure(input int lat, input string req);
        int t_c = -1, t_p = -1, t_k = -1;
        for (int k = 1; k <= lat + 3*TB_WIN + 4; k++) begin
            @(posedge clk); @(negedge clk);
            if (clkgen_rst_n && t_c < 0) t_c = k;
            if (periph_rst_n && t_p < 0) t_p = k;
            if (core_rst_n && t_k < 0) t_k = k;
        end
        chk(t_c == lat + TB_WIN,   {req, " clkgen"}, t_c, lat + TB_WIN);
        chk(t_p == lat + 2*TB_WIN, {req, " periph"}, t_p, lat + 2*TB_WIN);
        chk(t_k == lat + 3*TB_WIN, {req, " core"},   t_k, lat + 3*TB_WIN);
    endtask

    task automatic reg_write(input logic sel, input logic [3:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    // Applies a trigger; returns latency counted from the negedge it ends on.
    task automatic trigger(input int kind, output int lat);
        @(negedge clk);
        case (kind)
            K_WDOG: begin
                wdog_expire = 1'b1;
                @(negedge clk);
                wdog_expire = 1'b0;
                chk_all_low("R8 drop after wdog");
                lat = 0;
            end
            K_SW: begin
                reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 4'b0001;
                @(negedge clk);
                reg_we = 1'b0; reg_wdata = '0;
                chk(sw_rst_bit == 1'b1, "R7 control bit set", sw_rst_bit, 1);
                lat = 1;
            end
            K_PIN: begin
                ext_rst_n = 1'b0;
                #1;
                chk_all_low("R1 pin async assert");
                repeat (3) @(negedge clk);
                ext_rst_n = 1'b1;
                lat = 2;
            end
            default: begin
                por_req = 1'b1;
                #1;
                chk_all_low("R1 por async assert");
                repeat (3) @(negedge clk);
                por_req = 1'b0;
                lat = 2 + STAB_CYC;
            end
        endcase
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        int lat;
        // reset state
        #1 por_req = 1'b1;
        #1 chk_all_low("R1 outputs low at power-on");
        repeat (3) @(negedge clk);
        chk(cause_flags == 4'b0001, "R10 power-on flags", cause_flags, 1);
        chk(sw_rst_bit == 1'b0, "R7 control bit idle", sw_rst_bit, 0);
        por_req = 1'b0;
        measure(2 + STAB_CYC, "R3 R4 power-on release");

        // table walk
        for (int v = 0; v < 6; v++) begin
            int kind;
            kind = int'(VEC[v][5:4]);
            if (kind != K_POR) begin
                reg_write(1'b1, 4'hF);
                chk(cause_flags == 4'b0000, "R10 clear all flags", cause_flags, 0);
            end
            trigger(kind, lat);
            measure(lat, kind == K_PIN ? "R2 R4 pin release" :
                         kind == K_POR ? "R3 R4 por release" : "R4 R8 sync release");
            chk(cause_flags == VEC[v][3:0], "R9 cause after vector", cause_flags, VEC[v][3:0]);
            chk(sw_rst_bit == 1'b0, "R7 control bit self-clears", sw_rst_bit, 0);
        end

        // restart mid-sequence
        trigger(K_WDOG, lat);
        repeat (TB_WIN + 4) begin @(posedge clk); @(negedge clk); end
        chk(clkgen_rst_n == 1'b1 && periph_rst_n == 1'b0, "R6 mid-sequence state",
            {clkgen_rst_n, periph_rst_n}, 2);
        trigger(K_WDOG, lat);
        chk(clkgen_rst_n == 1'b0, "R6 restart drops clkgen", clkgen_rst_n, 0);
        measure(lat, "R6 restarted windows");

        // sticky accumulation
        reg_write(1'b1, 4'hF);
        trigger(K_PIN, lat);
        measure(lat, "R2 pin release");
        trigger(K_WDOG, lat);
        measure(lat, "R8 wdog release");
        chk(cause_flags == 4'b1010, "R9 sticky flags", cause_flags, 4'b1010);

        // partial write-one-to-clear
        reg_write(1'b1, 4'b0010);
        chk(cause_flags == 4'b1000, "R10 partial clear", cause_flags, 4'b1000);

        // set wins over clear on the same edge
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = 4'hF; wdog_expire = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0; wdog_expire = 1'b0;
        chk(cause_flags == 4'b1000, "R10 set wins over clear", cause_flags, 4'b1000);
        measure(0, "R8 wdog with clear");

        // power-on wipes flags
        trigger(K_POR, lat);
        measure(lat, "R3 power-on after run");
        chk(cause_flags == 4'b0001, "R10 power-on clears flags", cause_flags, 1);

        report();
    end
endmodule